// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block translates a 32-bit virtual address into a physical address by walking a two-level page table held in memory. The virtual address is split into three fields: a 10-bit top-level index in bits [31:22], a 10-bit leaf index in bits [21:12], and a 12-bit byte offset in bits [11:0]. Pages are 4 KB, so the space holds 2^20 pages. Each table holds 1024 four-byte entries and fills one 4 KB frame. A top-level entry covers a 4 MB region and points to the leaf table for that region. Regions that are not in use need no leaf table.

The block starts a walk when a request arrives while it is idle. It first reads the top-level entry at the root base plus four times the top index. If that entry is present, it reads the leaf entry at the leaf table's frame base plus four times the leaf index. The physical address is the leaf entry's frame number joined to the offset. Each memory read is a level request that the block holds, with a steady address, until a response-valid strobe arrives. That strobe may come after any number of cycles. An absent entry at either level ends the walk with a fault, and the fault output names the level.

Both table levels use the same entry format. Bit 0 is the present flag (1 = present). Bits [31:12] hold the frame number. Bits [11:1] are ignored.

Top module: `pt_walker`

## Requirements
- R1: After reset, ready_o is 1 and mem_req_o, done_o and fault_o are 0.
- R2: A request is taken only when ready_o is 1. While a walk runs, ready_o is 0, and req_valid_i and req_vaddr_i have no effect on that walk's reads or result.
- R3: The first read of a walk is at root_base_i (captured at acceptance) + 4 × vaddr[31:22].
- R4: If the top-level entry has bit 0 = 0, the walk ends with fault_o = 1 and fault_lvl_o = 0, and no second read is issued.
- R5: If the top-level entry has bit 0 = 1, the second read is at {entry[31:12], 12'h000} + 4 × vaddr[21:12].
- R6: If the leaf entry has bit 0 = 0, the walk ends with fault_o = 1 and fault_lvl_o = 1.
- R7: If the leaf entry is present, done_o pulses high for one cycle. During that cycle paddr_o = {leaf entry[31:12], vaddr[11:0]}. ready_o is 1 in the next cycle.
- R8: mem_req_o stays high and mem_addr_o stays stable until mem_rvalid_i is seen, whatever the response latency.
- R9: done_o and fault_o are never high together, and each lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Translation request strobe |
| req_vaddr_i | input | 32 | Virtual address to translate |
| root_base_i | input | 32 | Byte address of the top-level table |
| ready_o | output | 1 | Walker idle, a request will be taken |
| mem_req_o | output | 1 | Memory read request, held until response |
| mem_addr_o | output | 32 | Byte address of the entry being read |
| mem_rvalid_i | input | 1 | Read response valid |
| mem_rdata_i | input | 32 | Read response entry |
| done_o | output | 1 | One-cycle pulse: translation succeeded |
| paddr_o | output | 32 | Physical address, valid with done_o |
| fault_o | output | 1 | One-cycle pulse: walk ended on an absent entry |
| fault_lvl_o | output | 1 | Faulting level, 0 = top, 1 = leaf, valid with fault_o |

## Verification
A wrong walker state shows at the memory port within one cycle. It appears as a read at the wrong address, a second read after a top-level fault, or a request that drops before its response. The bench records every read address and compares it with addresses computed from the index fields. It sweeps 256 combinations of top and leaf index over a synthetic table, with both present and absent entries at each level and with latencies from 0 to 25 cycles. A wrong captured frame or offset shows up as a wrong paddr_o in the single done_o cycle. A bad exit from the done or fault state shows as a pulse longer than one cycle or as ready_o staying low.

// File: rtl/pt_walk_pkg.sv
package pt_walk_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_TOP,
    ST_RD_LEAF,
    ST_DONE,
    ST_FAULT
  } walk_st_e;

  localparam int unsigned PRESENT_BIT = 0;
endpackage

// File: rtl/pt_walk_addr.sv
module pt_walk_addr
  import pt_walk_pkg::*;
#(
  parameter int unsigned VA_W        = 32,
  parameter int unsigned IDX_W       = 10,
  parameter int unsigned OFF_W       = 12,
  parameter int unsigned PA_W        = 32,
  parameter int unsigned ENTRY_SHIFT = 2
) (
  input  walk_st_e              st_i,
  input  logic [VA_W-1:0]       vaddr_i,
  input  logic [PA_W-1:0]       root_i,
  input  logic [PA_W-OFF_W-1:0] tbl_frame_i,
  output logic [PA_W-1:0]       addr_o
);
  localparam int unsigned FRAME_W = PA_W - OFF_W;

  logic [IDX_W-1:0] top_idx, leaf_idx, idx;
  logic [PA_W-1:0]  base;
  logic             unused_off;

  assign top_idx    = vaddr_i[VA_W-1 -: IDX_W];
  assign leaf_idx   = vaddr_i[OFF_W +: IDX_W];
  assign unused_off = ^vaddr_i[OFF_W-1:0];

  always_comb begin
    if (st_i == ST_RD_LEAF) begin
      base = {tbl_frame_i[FRAME_W-1:0], {OFF_W{1'b0}}};
      idx  = leaf_idx;
    end else begin
      base = root_i;
      idx  = top_idx;
    end
    addr_o = base + (PA_W'(idx) << ENTRY_SHIFT);
  end
endmodule

// File: rtl/pt_walk_ctrl.sv
module pt_walk_ctrl
  import pt_walk_pkg::*;
#(
  parameter int unsigned VA_W  = 32,
  parameter int unsigned OFF_W = 12,
  parameter int unsigned PTE_W = 32
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   req_valid_i,
  input  logic [VA_W-1:0]        vaddr_i,
  input  logic [PTE_W-1:0]       root_i,
  input  logic                   rvalid_i,
  input  logic [PTE_W-1:0]       rdata_i,
  output walk_st_e               st_o,
  output logic [VA_W-1:0]        va_o,
  output logic [PTE_W-1:0]       root_o,
  output logic [PTE_W-OFF_W-1:0] tbl_frame_o,
  output logic [PTE_W-1:0]       paddr_o,
  output logic                   fault_lvl_o
);
  localparam int unsigned FRAME_W = PTE_W - OFF_W;

  walk_st_e           st_q;
  logic [VA_W-1:0]    va_q;
  logic [PTE_W-1:0]   root_q, pa_q;
  logic [FRAME_W-1:0] frame_q;
  logic               lvl_q;
  logic               present;
  logic               unused_flags;

  assign present      = rdata_i[PRESENT_BIT];
  assign unused_flags = ^rdata_i[OFF_W-1:1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      va_q    <= '0;
      root_q  <= '0;
      frame_q <= '0;
      pa_q    <= '0;
      lvl_q   <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (req_valid_i) begin
          va_q   <= vaddr_i;
          root_q <= root_i;
          st_q   <= ST_RD_TOP;
        end
        ST_RD_TOP: if (rvalid_i) begin
          if (present) begin
            frame_q <= rdata_i[PTE_W-1:OFF_W];
            st_q    <= ST_RD_LEAF;
          end else begin
            lvl_q <= 1'b0;
            st_q  <= ST_FAULT;
          end
        end
        ST_RD_LEAF: if (rvalid_i) begin
          if (present) begin
            pa_q <= {rdata_i[PTE_W-1:OFF_W], va_q[OFF_W-1:0]};
            st_q <= ST_DONE;
          end else begin
            lvl_q <= 1'b1;
            st_q  <= ST_FAULT;
          end
        end
        default: st_q <= ST_IDLE;  // DONE / FAULT last one cycle
      endcase
    end
  end

  assign st_o        = st_q;
  assign va_o        = va_q;
  assign root_o      = root_q;
  assign tbl_frame_o = frame_q;
  assign paddr_o     = pa_q;
  assign fault_lvl_o = lvl_q;
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walk_pkg::*;
#(
  parameter int unsigned IDX_W       = 10,
  parameter int unsigned OFF_W       = 12,
  parameter int unsigned ENTRY_SHIFT = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_valid_i,
  input  logic [31:0] req_vaddr_i,
  input  logic [31:0] root_base_i,
  output logic        ready_o,
  output logic        mem_req_o,
  output logic [31:0] mem_addr_o,
  input  logic        mem_rvalid_i,
  input  logic [31:0] mem_rdata_i,
  output logic        done_o,
  output logic [31:0] paddr_o,
  output logic        fault_o,
  output logic        fault_lvl_o
);
  localparam int unsigned VA_W  = 2 * IDX_W + OFF_W;
  localparam int unsigned PTE_W = 32;

  walk_st_e                st;
  logic [VA_W-1:0]         va;
  logic [PTE_W-1:0]        root;
  logic [PTE_W-OFF_W-1:0]  tbl_frame;

  pt_walk_ctrl #(.VA_W(VA_W), .OFF_W(OFF_W), .PTE_W(PTE_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .vaddr_i     (req_vaddr_i[VA_W-1:0]),
    .root_i      (root_base_i),
    .rvalid_i    (mem_rvalid_i),
    .rdata_i     (mem_rdata_i),
    .st_o        (st),
    .va_o        (va),
    .root_o      (root),
    .tbl_frame_o (tbl_frame),
    .paddr_o     (paddr_o),
    .fault_lvl_o (fault_lvl_o)
  );

  pt_walk_addr #(
    .VA_W(VA_W), .IDX_W(IDX_W), .OFF_W(OFF_W), .PA_W(PTE_W), .ENTRY_SHIFT(ENTRY_SHIFT)
  ) u_addr (
    .st_i        (st),
    .vaddr_i     (va),
    .root_i      (root),
    .tbl_frame_i (tbl_frame),
    .addr_o      (mem_addr_o)
  );

  assign ready_o   = (st == ST_IDLE);
  assign mem_req_o = (st == ST_RD_TOP) || (st == ST_RD_LEAF);
  assign done_o    = (st == ST_DONE);
  assign fault_o   = (st == ST_FAULT);

  AST_IDLE_NO_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> !mem_req_o);  // R2
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_rvalid_i) |=> (mem_req_o && $stable(mem_addr_o)));  // R8
  AST_TOP_FAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_RD_TOP && mem_rvalid_i && !mem_rdata_i[PRESENT_BIT]) |=> (fault_o && !fault_lvl_o));  // R4
  AST_LEAF_FAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_RD_LEAF && mem_rvalid_i && !mem_rdata_i[PRESENT_BIT]) |=> (fault_o && fault_lvl_o));  // R6
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && ready_o));  // R7
  AST_FAULT_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |=> (!fault_o && ready_o));  // R9
  AST_END_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && fault_o));  // R9
endmodule

// File: tb/pt_walker_test.sv
module pt_walker_test;
  localparam logic [31:0] ROOT = 32'h0001_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        ready, mem_req, mem_rvalid = 1'b0, done, fault, fault_lvl;
  logic [31:0] mem_addr, mem_rdata = '0, paddr;

  int errors = 0, checks = 0;
  int lat = 0, waitc = 0, nrd = 0;
  logic [31:0] seen [0:3];

  always #10ns clk = ~clk;

  pt_walker uut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_vaddr_i(req_vaddr),
    .root_base_i(ROOT), .ready_o(ready), .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata), .done_o(done), .paddr_o(paddr),
    .fault_o(fault), .fault_lvl_o(fault_lvl)
  );

  function automatic logic top_present(input int i);
    return (i % 3) != 2;
  endfunction
  function automatic logic leaf_present(input int i, input int j);
    return ((i + j) % 5) != 4;
  endfunction
  function automatic logic [19:0] leaf_frame(input int i, input int j);
    return 20'((i * 7 + j * 13 + 32'h3000) & 32'hF_FFFF);
  endfunction

  // synthetic memory: top table at ROOT, leaf table i at frame 0x100+i
  function automatic logic [31:0] mem_model(input logic [31:0] a);
    int i, j;
    if (a[31:12] == ROOT[31:12]) begin
      i = int'(a[11:2]);
      return {20'h100 + 20'(i), 11'h2A5, top_present(i)};
    end else if (a[31:12] >= 20'h100 && a[31:12] < 20'h500) begin
      i = int'(a[31:12] - 20'h100);
      j = int'(a[11:2]);
      return {leaf_frame(i, j), 11'h155, leaf_present(i, j)};
    end
    return 32'h0;
  endfunction

  task automatic check(input logic ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // responder: raise rvalid after lat cycles of a pending request
  initial forever begin
    @(negedge clk);
    if (mem_rvalid) begin
      mem_rvalid = 1'b0;
      waitc = 0;
    end else if (mem_req) begin
      if (waitc >= lat) begin
        mem_rvalid = 1'b1;
        mem_rdata  = mem_model(mem_addr);
        if (nrd < 4) seen[nrd] = mem_addr;
        nrd++;
      end else waitc++;
    end
  end

  task automatic walk(input int i, input int j, input logic [11:0] off, input logic poke);
    logic [31:0] va, exp_a0, exp_a1, exp_pa;
    int guard;
    va = {10'(i), 10'(j), off};
    exp_a0 = ROOT + 32'(i) * 4;
    exp_a1 = ((32'h100 + 32'(i)) << 12) + 32'(j) * 4;
    exp_pa = {leaf_frame(i, j), off};
    nrd = 0;
    req_valid = 1'b1;
    req_vaddr = va;
    @(negedge clk);
    check(!ready, "R2 busy", {31'b0, ready}, 32'h0);
    req_valid = poke;
    req_vaddr = ~va;
    @(negedge clk);
    req_valid = 1'b0;
    guard = 0;
    while (!(done || fault) && guard < 200) begin
      @(negedge clk);
      guard++;
    end
    check(nrd >= 1 && seen[0] == exp_a0, "R3 top addr", seen[0], exp_a0);
    if (!top_present(i)) begin
      check(fault && !fault_lvl && !done, "R4 top fault", {29'b0, done, fault, fault_lvl}, 32'h2);
      check(nrd == 1, "R4 single read", 32'(nrd), 32'd1);
    end else begin
      check(nrd == 2 && seen[1] == exp_a1, "R5 leaf addr", seen[1], exp_a1);
      if (!leaf_present(i, j))
        check(fault && fault_lvl && !done, "R6 leaf fault", {29'b0, done, fault, fault_lvl}, 32'h3);
      else begin
        check(done && !fault, "R7 done", {30'b0, done, fault}, 32'h2);
        check(paddr == exp_pa, "R7 paddr", paddr, exp_pa);
      end
    end
    @(negedge clk);
    check(!done && !fault && ready, "R9 one-cycle end", {29'b0, done, fault, ready}, 32'h1);
  endtask

  initial begin
    #(20ns * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(ready && !mem_req && !done && !fault, "R1 reset",
          {28'b0, ready, mem_req, done, fault}, 32'h8);
    rst_n = 1'b1;
    @(negedge clk);
    check(ready && !mem_req, "R1 after release", {30'b0, ready, mem_req}, 32'h2);
    for (int i = 0; i < 16; i++)
      for (int j = 0; j < 16; j++) begin
        lat = (i + j) % 4;  // R8 latency sweep
        walk(i, j, 12'((i * 37 + j * 101) & 12'hFFF), (j % 2) == 1);
      end
    lat = 25;  // R8 long latency
    walk(0, 0, 12'hABC, 1'b1);
    walk(2, 3, 12'h001, 1'b0);
    walk(4, 5, 12'hFFF, 1'b1);
    walk(1, 3, 12'h123, 1'b0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule